// File: doc/BRIEF.md
# Addressed Single-Output Update Latch

This block holds the on/off state of eight output channels and changes them one channel at a time through a small parallel port. The port has a channel address, a level bit and an active-low select strobe. When the strobe returns high, the channel named by the address is driven to the level and the other seven channels keep their values. The port pins are asynchronous to the block: the strobe passes through a synchronizer on the system clock, and the address and level are sampled in the clock cycle in which the synchronized rising edge is seen. The host must therefore hold address and level steady for a few clock cycles after it raises the strobe.

Two active-low override inputs act on all channels at once: one turns every channel on, the other turns every channel off. The all-off override wins over the all-on override and over the port. An update strobe that completes while either override is active is dropped, and the forced pattern stays in place after the override is released. The overrides are synchronized the same way as the strobe. The port carries single control writes with no flow of data, so every pin is a plain level and there is no handshake or back-pressure.

Top module: `chan_select_latch`

## Requirements
- R1: After `rst_n` is released, all eight bits of `drive_en` are 0, and they stay 0 until a port update or an override changes them.
- R2: The address is binary. Address value a (0 to 7) selects bit `drive_en[a]`. Address 000 is the first channel and 111 is the last. A level of 1 turns the selected bit on and a level of 0 turns it off.
- R3: An update happens only on a low-to-high transition of `sel_n`. Address and level are sampled in the cycle in which the synchronized rising edge is detected. `drive_en` does not change in the first clock cycle after the pin rises, and it shows the new value no more than four clock cycles after the pin rises.
- R4: An update leaves every bit other than the addressed one unchanged.
- R5: Changes on address and level have no effect while `sel_n` stays high or stays low. Only the values present at the detected rising edge count.
- R6: While `all_on_n` is low and `all_off_n` is high, `drive_en` is all ones. Port updates that complete during this time are dropped, and all ones remain after the release.
- R7: While `all_off_n` is low, `drive_en` is all zeros, whatever `all_on_n` and the port are doing. All zeros remain after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the port |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| sel_n | input | 1 | Active-low select strobe; its rising edge commits an update |
| addr | input | 3 | Binary channel address |
| level | input | 1 | New state for the addressed channel (1 = on) |
| all_on_n | input | 1 | Active-low override that turns all channels on |
| all_off_n | input | 1 | Active-low override that turns all channels off; dominant |
| drive_en | output | 8 | Channel states, bit a belongs to address a |

## Verification
The bench writes every address with both levels in turn, starting from an all-zero pattern and from an all-one pattern. A bad decoder would then touch the wrong bit or several bits, and a design that rebuilt the whole vector instead of doing a read-modify-write would clear neighbouring channels. It wiggles address and level while the strobe is held steady, both high and low. A design that was transparent, or that sampled on the falling edge, would move outputs there. It also checks that nothing changes one cycle after the pin rises, which catches a design that skips the synchronizer. The overrides are applied one at a time and together, with a strobe finishing inside each window. A design with the wrong priority, or that let the dropped write through after release, would show a wrong pattern.

// File: rtl/chan_select_latch_pkg.sv
package chan_select_latch_pkg;

  // Resolved override state after synchronization and priority.
  typedef enum logic [1:0] {
    OVR_NONE    = 2'b00,
    OVR_ALL_ON  = 2'b01,
    OVR_ALL_OFF = 2'b10
  } ovr_mode_e;

  // The all-off request dominates the all-on request.
  function automatic ovr_mode_e resolve_ovr(input logic on_req, input logic off_req);
    if (off_req)     return OVR_ALL_OFF;
    else if (on_req) return OVR_ALL_ON;
    else             return OVR_NONE;
  endfunction

endpackage

// File: rtl/cs_bit_sync.sv
module cs_bit_sync #(
  parameter int   WIDTH     = 1,
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {(STAGES*WIDTH){RESET_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cs_rise_detect.sv
module cs_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  // The idle level of the strobe is high, so reset to 1 so that no edge appears at reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/cs_onehot_decode.sv
module cs_onehot_decode #(
  parameter int N  = 8,
  parameter int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  onehot
);
  for (genvar g = 0; g < N; g++) begin : g_dec
    assign onehot[g] = (addr == AW'(g));
  end
endmodule

// File: rtl/cs_out_state.sv
module cs_out_state
  import chan_select_latch_pkg::*;
#(
  parameter int N = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  ovr_mode_e ovr,
  input  logic      upd,
  input  logic [N-1:0] sel_mask,
  input  logic      new_level,
  output logic [N-1:0] state
);
  logic [N-1:0] state_nxt;

  always_comb begin
    state_nxt = state;
    unique case (ovr)
      OVR_ALL_OFF: state_nxt = '0;
      OVR_ALL_ON:  state_nxt = '1;
      default: begin
        if (upd) state_nxt = (state & ~sel_mask) | (new_level ? sel_mask : '0);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/chan_select_latch.sv
module chan_select_latch
  import chan_select_latch_pkg::*;
#(
  parameter int NUM_OUT     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               level,
  input  logic               all_on_n,
  input  logic               all_off_n,
  output logic [NUM_OUT-1:0] drive_en
);
  logic [2:0]         ctl_s;
  logic               sel_n_s;
  logic               on_req;
  logic               off_req;
  logic               sel_rise;
  logic [NUM_OUT-1:0] sel_mask;
  ovr_mode_e          ovr;

  // All three control pins idle high; one synchronizer bank carries them.
  cs_bit_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sel_n, all_on_n, all_off_n}),
    .q(ctl_s)
  );

  assign sel_n_s = ctl_s[2];
  assign on_req  = ~ctl_s[1];
  assign off_req = ~ctl_s[0];
  assign ovr     = resolve_ovr(on_req, off_req);

  cs_rise_detect u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sel_n_s), .rise(sel_rise)
  );

  // Address and level are sampled directly in the commit cycle.
  cs_onehot_decode #(.N(NUM_OUT), .AW(ADDR_W)) u_dec (
    .addr(addr), .onehot(sel_mask)
  );

  cs_out_state #(.N(NUM_OUT)) u_state (
    .clk(clk), .rst_n(rst_n),
    .ovr(ovr), .upd(sel_rise), .sel_mask(sel_mask), .new_level(level),
    .state(drive_en)
  );
endmodule

// File: rtl/chan_select_latch_chk.sv
module chan_select_latch_chk #(
  parameter int NUM_OUT = 8,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  addr,
  input logic               level,
  input logic               upd,
  input logic               on_req,
  input logic               off_req,
  input logic [NUM_OUT-1:0] drive_en
);
  // R7: all-off request clears every channel on the next edge
  a_r7_off_dominant: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |=> (drive_en == '0));

  // R6: all-on request alone sets every channel
  a_r6_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    (on_req && !off_req) |=> (drive_en == '1));

  // R5: with no commit and no override the state holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !on_req && !off_req) |=> $stable(drive_en));

  // R4: a commit changes at most one channel
  a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !on_req && !off_req) |=> ($countones(drive_en ^ $past(drive_en)) <= 1));

  // R2: the addressed channel takes the sampled level
  a_r2_addr_level: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !on_req && !off_req) |=> (drive_en[$past(addr)] == $past(level)));
endmodule

bind chan_select_latch chan_select_latch_chk #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .level(level),
  .upd(sel_rise), .on_req(on_req), .off_req(off_req), .drive_en(drive_en)
);

// File: tb/tb_chan_select_latch.sv
module tb_chan_select_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1;
  logic [2:0] addr = '0;
  logic       level = 1'b0;
  logic       all_on_n = 1'b1;
  logic       all_off_n = 1'b1;
  logic [7:0] drive_en;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = '0;

  always #2 clk = ~clk;

  chan_select_latch dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .addr(addr), .level(level),
    .all_on_n(all_on_n), .all_off_n(all_off_n), .drive_en(drive_en)
  );

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (drive_en !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, drive_en, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Full strobe: drop select, present address and level, raise, hold for settling.
  task automatic strobe(input logic [2:0] a, input logic l);
    @(negedge clk);
    addr = a; level = l; sel_n = 1'b0;
    wait_n(3);
    sel_n = 1'b1;
    wait_n(6);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(3);
    check("R1 reset state", 8'h00);

    // R2 R4: set each channel from all-zeros, then clear each channel
    for (int a = 0; a < 8; a++) begin
      strobe(3'(a), 1'b1);
      model[a] = 1'b1;
      check("R2 R4 set sweep", model);
    end
    for (int a = 0; a < 8; a++) begin
      strobe(3'(a), 1'b0);
      model[a] = 1'b0;
      check("R2 R4 clear sweep", model);
    end
    // Isolated single bits on a clear background, then a single hole on a full background
    for (int a = 0; a < 8; a++) begin
      strobe(3'(a), 1'b1);
      check("R2 one-hot", 8'(1) << a);
      strobe(3'(a), 1'b0);
      check("R4 back to zero", 8'h00);
    end
    for (int a = 0; a < 8; a++) strobe(3'(a), 1'b1);
    for (int a = 0; a < 8; a++) begin
      strobe(3'(a), 1'b0);
      check("R4 single hole", ~(8'(1) << a));
      strobe(3'(a), 1'b1);
    end
    check("R2 all set", 8'hFF);
    model = 8'hFF;

    // R3: no change right after the pin rises, change within the window
    @(negedge clk);
    addr = 3'd5; level = 1'b0; sel_n = 1'b0;
    wait_n(3);
    sel_n = 1'b1;
    wait_n(1);
    check("R3 not before sync delay", model);
    wait_n(4);
    model[5] = 1'b0;
    check("R3 committed at rising edge", model);

    // R5: wiggle address and level while select is high
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); addr = 3'(a); level = a[0];
    end
    wait_n(6);
    check("R5 ignored while select high", model);
    // R5: wiggle while select is held low; only the final values count
    @(negedge clk); sel_n = 1'b0;
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); addr = 3'(a); level = 1'b0;
      wait_n(2);
      check("R5 ignored while select low", model);
    end
    addr = 3'd5; level = 1'b1;
    wait_n(3);
    sel_n = 1'b1;
    wait_n(6);
    model[5] = 1'b1;
    check("R5 final values at rise", model);

    // R7: all-off, with a strobe finishing inside the window
    strobe(3'd2, 1'b0);
    model[2] = 1'b0;
    @(negedge clk); all_off_n = 1'b0;
    wait_n(5);
    check("R7 all off", 8'h00);
    strobe(3'd6, 1'b1);
    check("R7 strobe dropped", 8'h00);
    @(negedge clk); all_off_n = 1'b1;
    wait_n(5);
    check("R7 zeros persist", 8'h00);

    // R6: all-on, with a clearing strobe dropped
    @(negedge clk); all_on_n = 1'b0;
    wait_n(5);
    check("R6 all on", 8'hFF);
    strobe(3'd3, 1'b0);
    check("R6 strobe dropped", 8'hFF);
    @(negedge clk); all_on_n = 1'b1;
    wait_n(5);
    check("R6 ones persist", 8'hFF);

    // R7 over R6: both low
    @(negedge clk); all_on_n = 1'b0; all_off_n = 1'b0;
    wait_n(5);
    check("R7 dominates R6", 8'h00);
    @(negedge clk); all_off_n = 1'b1;
    wait_n(5);
    check("R6 after off released", 8'hFF);
    @(negedge clk); all_on_n = 1'b1;
    wait_n(3);
    strobe(3'd0, 1'b0);
    check("R2 R4 update after overrides", 8'hFE);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule